// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives an 8-bit asynchronous flash or static memory port. Each accepted access runs as up to four timed phases: an optional bus turnaround gap, then address setup, the active strobe and a hold. The length of every phase comes from a 32-bit timing word. The word carries separate setup, strobe and hold counts for writes and for reads, plus a turnaround count. The word is captured when an access is accepted, so software may rewrite it while an access is in progress.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle, and a request is taken on the clock edge where `req_valid` and `req_ready` are both high. The requester holds the request stable until that edge. Two address bits pick the command latch line and the address latch line for the access, which is how command and address bytes reach a flash device. Read data comes back as a single-cycle `rsp_valid` pulse. That channel has no back-pressure, so the consumer must take the data in the cycle it appears. The device ready line is resynchronised and presented as a plain status output.

Top module: `amem_strobe_seq`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress, and a request is accepted on the edge where `req_valid` and `req_ready` are both high. The timing word is captured at acceptance, and later changes to it do not alter that access.
- R2: Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2]. Bits [31:30] and [1:0] have no effect.
- R3: Each phase lasts its field value plus one clock. `mem_cs_n` is low for exactly setup+1 + strobe+1 + hold+1 cycles of the access in progress.
- R4: `mem_we_n` is low only during the strobe phase of a write, and `mem_re_n` only during the strobe phase of a read. The two are never low together.
- R5: `req_addr[0]` drives `mem_cle` and `req_addr[1]` drives `mem_ale`. The selected line is high for every cycle that `mem_cs_n` is low in that access, and both lines are low whenever `mem_cs_n` is high.
- R6: On a read, `mem_din` is captured on the last clock of the strobe phase. It is presented on `rsp_data`, with `rsp_valid` high for exactly one cycle (the first hold cycle). Writes produce no `rsp_valid`.
- R7: On a write, `mem_dout` carries the accepted `req_wdata`, and `mem_oe` is high for every cycle `mem_cs_n` is low. `mem_oe` stays low during reads.
- R8: If an access has the opposite direction to the previous access since reset, turnaround+1 cycles with `mem_cs_n` high are inserted between acceptance and setup. Same-direction accesses and the first access after reset have no such gap.
- R9: `stat_ready` follows `mem_rdy` through two flip-flops, so it changes two clock edges after the input, and it is 0 during reset.
- R10: In reset, `mem_cs_n`, `mem_re_n` and `mem_we_n` are high, `mem_cle`, `mem_ale`, `mem_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Timing word, captured at acceptance |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Bit 0 selects command latch, bit 1 selects address latch |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cle | output | 1 | Command latch enable |
| mem_ale | output | 1 | Address latch enable |
| mem_oe | output | 1 | Data bus drive enable |
| mem_dout | output | 8 | Data driven to the memory |
| mem_din | input | 8 | Data returned by the memory |
| mem_rdy | input | 1 | Device ready, asynchronous |
| stat_ready | output | 1 | Synchronised device ready status |

## Verification
Read capture and the start of the hold phase happen on the same edge. The bench holds an inverted byte on `mem_din` through every strobe cycle except the last, so capturing data one cycle early or late returns the wrong value on `rsp_data`. Turnaround insertion and acceptance can also fall together. The bench presents opposite-direction requests as soon as `req_ready` rises, and it overwrites the timing word right after acceptance. The measured gap and the measured phase widths must then follow the captured word.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 8;

  localparam int WS_LSB = 26;
  localparam int WT_LSB = 20;
  localparam int WH_LSB = 17;
  localparam int RS_LSB = 13;
  localparam int RT_LSB = 7;
  localparam int RH_LSB = 4;
  localparam int TA_LSB = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [3:0] setup;
    logic [5:0] strobe;
    logic [2:0] hold;
  } dir_timing_t;

  typedef struct packed {
    dir_timing_t wr;
    dir_timing_t rd;
    logic [1:0]  turn;
  } timing_t;
endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
  import amem_pkg::*;
(
  input  logic [31:0] cfg,
  output timing_t     tim
);
  always_comb begin
    tim.wr.setup  = cfg[WS_LSB +: 4];
    tim.wr.strobe = cfg[WT_LSB +: 6];
    tim.wr.hold   = cfg[WH_LSB +: 3];
    tim.rd.setup  = cfg[RS_LSB +: 4];
    tim.rd.strobe = cfg[RT_LSB +: 6];
    tim.rd.hold   = cfg[RH_LSB +: 3];
    tim.turn      = cfg[TA_LSB +: 2];
  end
endmodule

// File: rtl/amem_sync.sv
module amem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  timing_t           tim,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output phase_e            ph,
  output logic              wr,
  output logic [1:0]        addr_sel,
  output logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [CNT_W-1:0] cnt;
  dir_timing_t      dt_q;
  logic             have_prev, prev_wr;
  dir_timing_t      dt_in;

  assign dt_in = req_write ? tim.wr : tim.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      dt_q      <= '0;
      wr        <= 1'b0;
      addr_sel  <= '0;
      wdata     <= '0;
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          dt_q     <= dt_in;
          wr       <= req_write;
          addr_sel <= req_addr;
          wdata    <= req_wdata;
          if (have_prev && (prev_wr != req_write)) begin
            ph  <= PH_TURN;
            cnt <= CNT_W'(tim.turn);
          end else begin
            ph  <= PH_SETUP;
            cnt <= CNT_W'(dt_in.setup);
          end
        end
        PH_TURN: if (cnt == '0) begin
          ph  <= PH_SETUP;
          cnt <= CNT_W'(dt_q.setup);
        end else cnt <= cnt - 1'b1;
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_STROBE;
          cnt <= dt_q.strobe;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          ph  <= PH_HOLD;
          cnt <= CNT_W'(dt_q.hold);
          if (!wr) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_din;
          end
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          ph        <= PH_IDLE;
          have_prev <= 1'b1;
          prev_wr   <= wr;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_turn_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TURN) |-> (cnt <= CNT_W'(3)));
  p_hold_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HOLD) |-> (cnt <= CNT_W'(7)));
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
  import amem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_cs_n,
  output logic              mem_re_n,
  output logic              mem_we_n,
  output logic              mem_cle,
  output logic              mem_ale,
  output logic              mem_oe,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_rdy,
  output logic              stat_ready
);
  timing_t           tim;
  phase_e            ph;
  logic              wr;
  logic [1:0]        addr_sel;
  logic [DATA_W-1:0] wdata;
  logic              active;

  amem_cfg_decode u_dec (.cfg(cfg_word), .tim(tim));

  amem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tim(tim),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_din(mem_din),
    .ph(ph), .wr(wr), .addr_sel(addr_sel), .wdata(wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  amem_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk(clk), .rst_n(rst_n), .d(mem_rdy), .q(stat_ready)
  );

  assign active    = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  assign req_ready = (ph == PH_IDLE);
  assign mem_cs_n  = !active;
  assign mem_we_n  = !((ph == PH_STROBE) && wr);
  assign mem_re_n  = !((ph == PH_STROBE) && !wr);
  assign mem_cle   = active && addr_sel[0];
  assign mem_ale   = active && addr_sel[1];
  assign mem_oe    = active && wr;
  assign mem_dout  = wdata;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_re_n && mem_we_n));
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n));
  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !mem_cs_n);
  p_latch_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cle || mem_ale) |-> !mem_cs_n);
  p_rsp_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_cs_n && mem_re_n && $fell(mem_re_n) == 1'b0));
  p_oe_not_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> mem_re_n);
endmodule

// File: tb/amem_strobe_seq_bench.sv
module amem_strobe_seq_bench;
  typedef struct packed {
    logic       w;
    logic [1:0] addr;
    logic [7:0] wd;
    logic [7:0] din;
    logic [3:0] ws; logic [5:0] wt; logic [2:0] wh;
    logic [3:0] rs; logic [5:0] rt; logic [2:0] rh;
    logic [1:0] ta;
    logic [3:0] junk;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 8'hA5, 8'h00, 4'd1,  6'd3,  3'd1, 4'd1,  6'd5,  3'd1, 2'd3, 4'h0},
    '{1'b1, 2'd2, 8'h3C, 8'h00, 4'd0,  6'd0,  3'd0, 4'd1,  6'd5,  3'd1, 2'd3, 4'h0},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd1,  6'd1,  3'd1, 4'd2,  6'd5,  3'd0, 2'd1, 4'h0},
    '{1'b0, 2'd0, 8'h00, 8'hC3, 4'd1,  6'd1,  3'd1, 4'd0,  6'd0,  3'd2, 2'd3, 4'hF},
    '{1'b1, 2'd3, 8'h0F, 8'h00, 4'd15, 6'd63, 3'd7, 4'd1,  6'd1,  3'd1, 2'd0, 4'h0},
    '{1'b0, 2'd1, 8'h00, 8'h81, 4'd1,  6'd1,  3'd1, 4'd15, 6'd63, 3'd7, 2'd3, 4'hA},
    '{1'b1, 2'd0, 8'hFF, 8'h00, 4'd2,  6'd1,  3'd3, 4'd1,  6'd1,  3'd1, 2'd2, 4'h5},
    '{1'b0, 2'd2, 8'h00, 8'h7E, 4'd1,  6'd1,  3'd1, 4'd1,  6'd2,  3'd1, 2'd0, 4'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0, mem_din = '0;
  logic mem_rdy = 1'b0;
  logic req_ready, rsp_valid, mem_cs_n, mem_re_n, mem_we_n;
  logic mem_cle, mem_ale, mem_oe, stat_ready;
  logic [7:0] rsp_data, mem_dout;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  amem_strobe_seq u_amem_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_oe(mem_oe),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_rdy(mem_rdy),
    .stat_ready(stat_ready)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  bit have_prev = 0, prev_w = 0;

  task automatic run(int i);
    vec_t v = VECS[i];
    int gap = 0, cs = 0, st = 0, wrong = 0, cle = 0, ale = 0, oe = 0;
    int stray = 0, rv = 0, rdy_hi = 0, dbad = 0;
    int exp_gap, ph_s, ph_t, ph_h;
    logic [7:0] rd = '0;
    bit started = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.w; req_addr = v.addr; req_wdata = v.wd;
    cfg_word = {v.junk[3:2], v.ws, v.wt, v.wh, v.rs, v.rt, v.rh, v.ta, v.junk[1:0]};
    mem_din = ~v.din;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; cfg_word = 32'h0; req_wdata = 8'h00;
    forever begin
      if (!mem_cs_n) begin
        started = 1; cs++;
        if (mem_cle) cle++;
        if (mem_ale) ale++;
        if (mem_oe) oe++;
        if (!mem_we_n) begin
          if (v.w) st++; else wrong++;
          if (mem_dout != v.wd) dbad++;
        end
        if (!mem_re_n) begin
          if (!v.w) st++; else wrong++;
          mem_din = (st == int'(v.rt) + 1) ? v.din : ~v.din;
        end
      end else begin
        if (!started) gap++;
        if (mem_cle || mem_ale || mem_oe) stray++;
      end
      if (req_ready && !started) rdy_hi++;
      if (!mem_cs_n && req_ready) rdy_hi++;
      if (rsp_valid) begin rv++; rd = rsp_data; end
      if (started && mem_cs_n) break;
      @(negedge clk);
    end
    ph_s = v.w ? int'(v.ws) : int'(v.rs);
    ph_t = v.w ? int'(v.wt) : int'(v.rt);
    ph_h = v.w ? int'(v.wh) : int'(v.rh);
    exp_gap = (have_prev && prev_w != v.w) ? int'(v.ta) + 1 : 0;
    check($sformatf("R1 busy ready v%0d", i), rdy_hi, 0);
    check($sformatf("R3 R2 cs width v%0d", i), cs, ph_s + ph_t + ph_h + 3);
    check($sformatf("R4 strobe width v%0d", i), st, ph_t + 1);
    check($sformatf("R4 wrong strobe v%0d", i), wrong, 0);
    check($sformatf("R5 cle v%0d", i), cle, v.addr[0] ? cs : 0);
    check($sformatf("R5 ale v%0d", i), ale, v.addr[1] ? cs : 0);
    check($sformatf("R5 stray latch v%0d", i), stray, 0);
    check($sformatf("R7 oe v%0d", i), oe, v.w ? cs : 0);
    check($sformatf("R7 dout v%0d", i), dbad, 0);
    check($sformatf("R6 rsp count v%0d", i), rv, v.w ? 0 : 1);
    if (!v.w) check($sformatf("R6 rsp data v%0d", i), int'(rd), int'(v.din));
    check($sformatf("R8 gap v%0d", i), gap, exp_gap);
    have_prev = 1; prev_w = v.w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 cs_n", int'(mem_cs_n), 1);
    check("R10 re_n", int'(mem_re_n), 1);
    check("R10 we_n", int'(mem_we_n), 1);
    check("R10 latches", int'({mem_cle, mem_ale, mem_oe}), 0);
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 req_ready", int'(req_ready), 1);
    check("R9 reset status", int'(stat_ready), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run(i);
    @(negedge clk);
    mem_rdy = 1'b1;
    @(negedge clk);
    check("R9 one edge", int'(stat_ready), 0);
    @(negedge clk);
    check("R9 two edges", int'(stat_ready), 1);
    mem_rdy = 1'b0;
    @(negedge clk);
    check("R9 fall one edge", int'(stat_ready), 1);
    @(negedge clk);
    check("R9 fall two edges", int'(stat_ready), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule